// File: doc/BRIEF.md
# ID-Filtered Multi-Line Serial Dispatcher

The dispatcher takes a single stream of correction packets and offers each packet to a whole array of identical serial line transmitters at once. Each packet carries a 16-bit target ID and a correction value. Every line holds its own configuration word with a target ID and an enable bit. A line keeps only packets whose ID matches its configuration exactly, and then sends the correction value on its own wire as a framed asynchronous serial word.

Two programmable dividers share timing across all lines. A bit-rate tick sets how long each serial bit lasts. A word-period tick sets when lines may start a word. A captured value waits in a per-line buffer with a pending flag until the next period tick finds the line's transmitter idle. A newer matching packet replaces a value that has not been sent yet. The stream input never applies back-pressure: `s_tready` is always high, and a beat is taken on every cycle where `s_tvalid` is high. A global enable stops all transmission at once and holds every line at its idle level.

Top module: `serial_line_dispatcher`

## Requirements
- R1: `s_tready` is high in every cycle, and a beat counts as presented whenever `s_tvalid` is high. Beat layout: `s_tdata[ID_W+VAL_W-1:VAL_W]` is the packet ID and `s_tdata[VAL_W-1:0]` is the correction value.
- R2: Line i captures a beat only when its configuration bit ID_W (the enable) is 1 and configuration bits ID_W-1:0 equal the packet ID. An unmatched or disabled line never changes its output.
- R3: A newer matching packet overwrites a value that is still pending. If a capture and a launch happen in the same cycle, the older buffered value is sent and the new one stays pending.
- R4: A line launches on a cycle where the period tick is high, its value is pending, the module is enabled and its transmitter is idle. The launch clears the pending flag, and the start bit appears on `line_tx` in the following cycle. A pending value that meets a busy transmitter waits for a later period tick.
- R5: The frame is, in time order: a start bit 0, then VAL_W data bits with the LSB first, then an even-parity bit (the XOR of the data bits), then a stop bit 1. Each bit holds until the next bit-rate tick. After the stop bit's tick the line returns to 1.
- R6: Each divider uses a counter that is cleared by reset. A divider value of 0 or 1 gives a tick on every clock. A value N ≥ 2 gives a one-cycle tick whenever the counter has reached N-1 or more, and the tick clears the counter. So ticks come every N clocks, and the first one comes N clocks after reset.
- R7: While `mod_enable` is low, every `line_tx` is 1 in the same cycle, a word in progress is abandoned, and no line launches. Matching packets are still captured as pending.
- R8: During and after reset, every `line_tx` is 1 and no value is pending.
- R9: Lines are independent. Several lines with the same configured ID all capture and send the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream ready, constant 1 |
| s_tdata | input | ID_W+VAL_W | Packet: ID in the upper bits, correction value in the lower bits |
| mod_enable | input | 1 | Global transmit enable |
| rate_div | input | DIV_W | Clocks per serial bit |
| period_div | input | DIV_W | Clocks per word-launch opportunity |
| line_cfg | input | NUM_LINES*(ID_W+1) | Per-line {enable, target ID}; line i at bits [i*(ID_W+1) +: ID_W+1] |
| line_tx | output | NUM_LINES | Serial outputs, idle high |

## Verification
The bench builds the block with NUM_LINES=4, ID_W=16, VAL_W=8 and DIV_W=32. With these values a whole frame takes a few dozen cycles, so overwrite, busy deferral, enable toggling mid-word and divider changes all fit in a short run. Four lines are enough for one unmatched line, one disabled line and two lines sharing an ID. The rate divider runs at 0, 1, 2 and 3, which covers the every-clock case and the counted case. The period divider is pushed down to 1, so launch requests reach lines that are still busy.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // start bit, parity bit and stop bit added around the data bits
  localparam int SLD_FRAME_OVERHEAD = 3;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_state_e;
endpackage

// File: rtl/sld_tick_gen.sv
module sld_tick_gen #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (div <= DIV_W'(1)) || (cnt_q >= div - DIV_W'(1));
  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else cnt_q <= cnt_q + DIV_W'(1);
  end

  // with a steady divider above one, ticks never come back to back
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1)) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/sld_line.sv
module sld_line
  import sld_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             rate_tick,
  input  logic             period_tick,
  input  logic             pkt_valid,
  input  logic [ID_W-1:0]  pkt_id,
  input  logic [VAL_W-1:0] pkt_val,
  input  logic [ID_W:0]    cfg,
  output logic             tx
);
  localparam int FRAME_W = VAL_W + SLD_FRAME_OVERHEAD;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [VAL_W-1:0]   buf_q;
  logic               pend_q;
  tx_state_e          state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               hit;
  logic               launch;
  logic [FRAME_W-1:0] frame;

  assign hit    = pkt_valid && cfg[ID_W] && (cfg[ID_W-1:0] == pkt_id);
  assign launch = period_tick && pend_q && mod_en && (state_q == TX_IDLE);
  assign frame  = {1'b1, ^buf_q, buf_q, 1'b0};
  assign tx     = shreg_q[0] | ~mod_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      pend_q  <= 1'b0;
      state_q <= TX_IDLE;
      shreg_q <= '1;
      cnt_q   <= '0;
    end else begin
      if (hit) begin
        buf_q  <= pkt_val;
        pend_q <= 1'b1;
      end else if (launch) begin
        pend_q <= 1'b0;
      end

      if (!mod_en) begin
        state_q <= TX_IDLE;
        shreg_q <= '1;
        cnt_q   <= '0;
      end else if (launch) begin
        state_q <= TX_BUSY;
        shreg_q <= frame;
        cnt_q   <= CNT_W'(FRAME_W);
      end else if (state_q == TX_BUSY && rate_tick) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        cnt_q   <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_q <= TX_IDLE;
      end
    end
  end

  assert_capture_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(pkt_valid && cfg[ID_W] && cfg[ID_W-1:0] == pkt_id));

  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !tx);

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_BUSY && cnt_q == CNT_W'(1)) |-> tx);

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> tx);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (state_q == TX_IDLE));
endmodule

// File: rtl/serial_line_dispatcher.sv
module serial_line_dispatcher #(
  parameter int NUM_LINES = 32,
  parameter int ID_W      = 16,
  parameter int VAL_W     = 32,
  parameter int DIV_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          s_tvalid,
  output logic                          s_tready,
  input  logic [ID_W+VAL_W-1:0]         s_tdata,
  input  logic                          mod_enable,
  input  logic [DIV_W-1:0]              rate_div,
  input  logic [DIV_W-1:0]              period_div,
  input  logic [NUM_LINES*(ID_W+1)-1:0] line_cfg,
  output logic [NUM_LINES-1:0]          line_tx
);
  localparam int CFG_W = ID_W + 1;

  logic             rate_tick;
  logic             period_tick;
  logic [ID_W-1:0]  pkt_id;
  logic [VAL_W-1:0] pkt_val;

  assign s_tready = 1'b1;
  assign pkt_id   = s_tdata[VAL_W +: ID_W];
  assign pkt_val  = s_tdata[VAL_W-1:0];

  sld_tick_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .div(rate_div), .tick(rate_tick)
  );

  sld_tick_gen #(.DIV_W(DIV_W)) u_period (
    .clk(clk), .rst_n(rst_n), .div(period_div), .tick(period_tick)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    sld_line #(.ID_W(ID_W), .VAL_W(VAL_W)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_en      (mod_enable),
      .rate_tick   (rate_tick),
      .period_tick (period_tick),
      .pkt_valid   (s_tvalid),
      .pkt_id      (pkt_id),
      .pkt_val     (pkt_val),
      .cfg         (line_cfg[i*CFG_W +: CFG_W]),
      .tx          (line_tx[i])
    );
  end

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_enable |-> (line_tx == '1));
endmodule

// File: tb/serial_line_dispatcher_tb.sv
`timescale 1ns/1ps
module serial_line_dispatcher_tb;
  localparam int NL = 4;
  localparam int IW = 16;
  localparam int VW = 8;
  localparam int FW = VW + 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [IW+VW-1:0] s_tdata = '0;
  logic mod_enable = 1'b1;
  logic [31:0] rate_div = 32'd3;
  logic [31:0] period_div = 32'd50;
  logic [NL*(IW+1)-1:0] line_cfg = '0;
  logic [NL-1:0] line_tx;

  always #2.5 clk = ~clk;

  serial_line_dispatcher #(.NUM_LINES(NL), .ID_W(IW), .VAL_W(VW), .DIV_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tdata(s_tdata), .mod_enable(mod_enable), .rate_div(rate_div),
    .period_div(period_div), .line_cfg(line_cfg), .line_tx(line_tx)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R8 reset";
  bit [NL-1:0] low_seen;

  // behavioural reference state
  longint m_rc, m_pc;
  bit     m_pend[NL];
  bit     m_act[NL];
  int     m_k[NL];
  logic [VW-1:0] m_buf[NL];
  logic [VW-1:0] m_word[NL];

  function automatic logic frame_bit(logic [VW-1:0] v, int k);
    if (k == 0) return 1'b0;
    if (k <= VW) return v[k-1];
    if (k == VW + 1) return ^v;
    return 1'b1;
  endfunction

  function automatic logic exp_tx(int i);
    if (!mod_enable || !m_act[i]) return 1'b1;
    return frame_bit(m_word[i], m_k[i]);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit rt, pt;
    cycles++;
    if (!rst_n) begin
      m_rc = 0; m_pc = 0;
      for (int i = 0; i < NL; i++) begin
        m_pend[i] = 0; m_act[i] = 0; m_k[i] = 0; m_buf[i] = '0; m_word[i] = '0;
      end
    end else begin
      rt = (rate_div <= 1) || (m_rc >= longint'(rate_div) - 1);
      pt = (period_div <= 1) || (m_pc >= longint'(period_div) - 1);
      for (int i = 0; i < NL; i++) begin
        logic [IW:0] c;
        bit hit, go;
        c = line_cfg[i*(IW+1) +: IW+1];
        hit = s_tvalid && c[IW] && (c[IW-1:0] == s_tdata[VW +: IW]);
        go = pt && m_pend[i] && mod_enable && !m_act[i];
        if (!mod_enable) m_act[i] = 0;
        else if (go) begin m_act[i] = 1; m_k[i] = 0; m_word[i] = m_buf[i]; end
        else if (m_act[i] && rt) begin
          m_k[i]++;
          if (m_k[i] == FW) m_act[i] = 0;
        end
        if (hit) begin m_buf[i] = s_tdata[VW-1:0]; m_pend[i] = 1; end
        else if (go) m_pend[i] = 0;
      end
      m_rc = rt ? 0 : m_rc + 1;
      m_pc = pt ? 0 : m_pc + 1;
    end
    #1;
    if (!done) begin
      check(s_tready === 1'b1, "R1 ready", s_tready, 1);
      for (int i = 0; i < NL; i++) begin
        check(line_tx[i] === exp_tx(i), cur_req, line_tx[i], exp_tx(i));
        if (line_tx[i] === 1'b0) low_seen[i] = 1'b1;
      end
    end
  end

  function automatic logic [IW:0] cfg_word(bit en, logic [IW-1:0] id);
    return {en, id};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [IW-1:0] id, logic [VW-1:0] v);
    s_tvalid = 1'b1;
    s_tdata = {id, v};
    @(negedge clk);
    s_tvalid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    line_cfg[0*(IW+1) +: IW+1] = cfg_word(1, 16'h1234);
    line_cfg[1*(IW+1) +: IW+1] = cfg_word(1, 16'h00AB);
    line_cfg[2*(IW+1) +: IW+1] = cfg_word(1, 16'h1234);
    line_cfg[3*(IW+1) +: IW+1] = cfg_word(0, 16'h1234);
    step(4);
    check(line_tx === '1, "R8 reset idle high", line_tx, 4'hF);
    rst_n = 1'b1;
    step(2);
    check(line_tx === '1, "R8 after reset", line_tx, 4'hF);
    check(s_tready === 1'b1, "R1 ready after reset", s_tready, 1);

    cur_req = "R2 R9 capture and broadcast";
    low_seen = '0;
    send(16'h1234, 8'hA5);
    step(120);
    check(low_seen[3] == 1'b0, "R2 disabled line silent", low_seen[3], 0);
    check(low_seen[1] == 1'b0, "R2 unmatched line silent", low_seen[1], 0);
    check(low_seen[0] && low_seen[2], "R9 shared ID both send", {low_seen[2], low_seen[0]}, 2'b11);

    cur_req = "R3 overwrite pending";
    low_seen = '0;
    send(16'h00AB, 8'h3C);
    send(16'h00AB, 8'hC3);
    step(120);
    check(low_seen[1] == 1'b1, "R3 line 1 sent", low_seen[1], 1);
    check(low_seen[0] == 1'b0, "R2 line 0 silent for other ID", low_seen[0], 0);

    cur_req = "R6 R4 divider 0 and 1 with busy deferral";
    rate_div = 32'd0;
    period_div = 32'd1;
    low_seen = '0;
    send(16'h1234, 8'h11);
    step(3);
    send(16'h1234, 8'h22);
    step(40);
    check(low_seen[0] == 1'b1, "R6 fast divider line 0 sent", low_seen[0], 1);
    rate_div = 32'd1;
    period_div = 32'd7;
    send(16'h1234, 8'hFF);
    send(16'h00AB, 8'h00);
    step(60);

    cur_req = "R7 module enable";
    rate_div = 32'd2;
    period_div = 32'd10;
    send(16'h1234, 8'h5A);
    step(14);
    mod_enable = 1'b0;
    step(1);
    check(line_tx === '1, "R7 all high when off", line_tx, 4'hF);
    low_seen = '0;
    send(16'h00AB, 8'h77);
    step(25);
    check(low_seen == '0, "R7 no launch while off", low_seen, 0);
    mod_enable = 1'b1;
    step(60);
    check(low_seen[1] == 1'b1, "R7 captured while off then sent", low_seen[1], 1);

    cur_req = "R5 frame shape";
    rate_div = 32'd3;
    period_div = 32'd40;
    send(16'h1234, 8'h96);
    send(16'h00AB, 8'h81);
    step(100);
    check(line_tx === '1, "R5 lines idle high after frames", line_tx, 4'hF);

    finish_run();
  end
endmodule